// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block hands a shared external memory bus over to an outside master and takes it back again. The outside master requests the bus by pulling an active-low request pin low. The controller synchronizes that pin and tells the local memory controller not to start anything new. It then waits for any local transfer in flight to finish. After that it turns off the bus output drivers, and only then pulls the active-low acknowledge low. When the request goes high again, the controller waits a bounded number of cycles and re-enables the drivers. It raises the acknowledge only after the drivers are back on.

A static blocking input lets software keep the bus local: while it is high, a request never leaves idle. If the input is raised while a request is still waiting for the local controller, that request is dropped. Each phase lasts a minimum number of clock cycles, set by parameters. These minimums keep the handover inside the required windows. The bus being released covers four chip selects, four byte enables, 32 data lines, 20 word-address lines and three shared strobes. All of them are switched together by the one output-enable.

There is no data stream in this block, so there is no valid/ready interface. Every pin is a plain level-sensitive control or status signal. The request pin may change at any time. All other inputs are synchronous to `clk`. Parameter limits: the synchronizer has at least 2 stages, and every phase minimum is at least 1.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `holda_n_o`=1, `bus_oe_o`=1 (bus driven) and `hold_pend_o`=0.
- R2: The request pin passes through a 2-stage synchronizer. If it is first sampled low at clock edge k (with blocking off), `hold_pend_o` goes to 1 after edge k+2. It is 0 before that.
- R3: The drivers turn off (`bus_oe_o`=0) at the first edge at or after k+3 at which `busy_i` is sampled low. `busy_i` sampled high always keeps the bus driven. With no local transfer, the bus floats after edge k+3, at least 2 cycles after the request was sampled.
- R4: `holda_n_o` falls exactly one edge after `bus_oe_o` falls. The bus is never driven on the edge that acknowledge falls.
- R5: While `nohold_i`=1, a request never reaches the waiting phase. `hold_pend_o` stays 0, `holda_n_o` stays 1 and the bus stays driven.
- R6: If `nohold_i` is sampled 1 while a request is waiting for the local controller, `hold_pend_o` returns to 0 after that edge and no grant follows.
- R7: A release of the request is not acted upon until 4 edges after acknowledge fell. If the request is sampled high at edge m, the re-drive phase begins at edge max(g+4, m+2), where g is the edge at which acknowledge fell.
- R8: The drivers turn on again 3 edges after the re-drive phase begins. For a release sampled at edge m with the minimum hold already met, this is edge m+5, which is within 2 to 7 cycles.
- R9: `holda_n_o` returns to 1 exactly one edge after `bus_oe_o` returns to 1.
- R10: `hold_pend_o` is 1 from the waiting phase until `holda_n_o` returns to 1, and in particular whenever `holda_n_o`=0.
- R11: If the request is withdrawn before the bus floats (synchronized value low while waiting), the block returns to idle. `hold_pend_o` drops and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n_i | input | 1 | Active-low bus request from the outside master, asynchronous |
| nohold_i | input | 1 | 1 = never hand the bus over |
| busy_i | input | 1 | 1 = local controller has a transfer in flight |
| hold_pend_o | output | 1 | 1 = local controller must not start a new transfer |
| bus_oe_o | output | 1 | 1 = local bus drivers enabled, 0 = bus at high impedance |
| holda_n_o | output | 1 | Active-low acknowledge to the outside master |

## Verification
The bench sweeps the local-transfer length against the request length and predicts every output on every cycle. This catches a design that floats the bus while a transfer is still running, or that acknowledges before or together with the float. It releases the request right after the acknowledge. A design that ignores the minimum hold then re-drives too early, and one that mistimes the re-drive either leaves the 2-to-7-cycle window or raises the acknowledge before the drivers are back. Blocking is exercised both before a request and while one is waiting, and so is withdrawal of a waiting request. A design that still grants in any of these cases, or leaves the pending flag stuck high, is reported.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_TRI,
    ST_GRANT,
    ST_REDRV,
    ST_REL
  } bhc_state_e;

  function automatic int bhc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bhc_hold_sync.sv
module bhc_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_n_i,
  output logic req_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], ~hold_n_i};
  end

  assign req_o = sh_q[STAGES-1];
endmodule

// File: rtl/bhc_phase_timer.sv
module bhc_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_o <= '0;
    else if (clr_i)         cnt_o <= '0;
    else if (cnt_o != CMAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bhc_hold_seq.sv
module bhc_hold_seq
  import bhc_pkg::*;
#(
  parameter int CW        = 3,
  parameter int WAIT_CYC  = 1,
  parameter int ACK_CYC   = 1,
  parameter int GRANT_CYC = 4,
  parameter int REDRV_CYC = 3,
  parameter int REL_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          nohold_i,
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clr_o,
  output logic          hold_pend_o,
  output logic          bus_oe_o,
  output logic          holda_n_o
);
  localparam logic [CW-1:0] LIM_W = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] LIM_A = CW'(ACK_CYC - 1);
  localparam logic [CW-1:0] LIM_G = CW'(GRANT_CYC - 1);
  localparam logic [CW-1:0] LIM_D = CW'(REDRV_CYC - 1);
  localparam logic [CW-1:0] LIM_R = CW'(REL_CYC - 1);

  bhc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i && !nohold_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!req_i || nohold_i)            st_d = ST_IDLE;
        else if (cnt_i >= LIM_W && !busy_i) st_d = ST_TRI;
      end
      ST_TRI:   if (cnt_i >= LIM_A)            st_d = ST_GRANT;
      ST_GRANT: if (cnt_i >= LIM_G && !req_i)  st_d = ST_REDRV;
      ST_REDRV: if (cnt_i >= LIM_D)            st_d = ST_REL;
      ST_REL:   if (cnt_i >= LIM_R)            st_d = ST_IDLE;
      default:                                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign clr_o       = (st_d != st_q);
  assign hold_pend_o = (st_q != ST_IDLE);
  assign bus_oe_o    = !(st_q == ST_TRI || st_q == ST_GRANT || st_q == ST_REDRV);
  assign holda_n_o   = !(st_q == ST_GRANT || st_q == ST_REDRV || st_q == ST_REL);

  // R2: pending flag only rises after a synchronized request
  a_r2_pend_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_pend_o) |-> $past(req_i));
  // R3: a running local transfer keeps the bus driven
  a_r3_busy_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && busy_i) |=> bus_oe_o);
  // R4: bus already floating on the cycle before acknowledge
  a_r4_float_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holda_n_o) |-> (!bus_oe_o && $past(!bus_oe_o)));
  // R5 / R6: blocking keeps or sends the sequencer to idle
  a_r5_nohold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (nohold_i && (st_q == ST_IDLE || st_q == ST_WAIT)) |=> st_q == ST_IDLE);
  // R7: granted phase lasts at least its minimum
  a_r7_grant_min: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GRANT && cnt_i < LIM_G) |=> !holda_n_o && !bus_oe_o);
  // R9: drivers back on before acknowledge rises
  a_r9_drive_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda_n_o) |-> (bus_oe_o && $past(bus_oe_o)));
  // R10: pending flag covers the granted interval
  a_r10_pend_cover: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n_o |-> hold_pend_o);
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYC    = 1,
  parameter int ACK_CYC     = 1,
  parameter int GRANT_CYC   = 4,
  parameter int REDRV_CYC   = 3,
  parameter int REL_CYC     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_n_i,
  input  logic nohold_i,
  input  logic busy_i,
  output logic hold_pend_o,
  output logic bus_oe_o,
  output logic holda_n_o
);
  localparam int MAXC = bhc_max(bhc_max(bhc_max(WAIT_CYC, ACK_CYC),
                                        bhc_max(GRANT_CYC, REDRV_CYC)), REL_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic          req;
  logic          clr;
  logic [CW-1:0] cnt;

  bhc_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n_i), .req_o(req)
  );

  bhc_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cnt_o(cnt)
  );

  bhc_hold_seq #(
    .CW(CW), .WAIT_CYC(WAIT_CYC), .ACK_CYC(ACK_CYC), .GRANT_CYC(GRANT_CYC),
    .REDRV_CYC(REDRV_CYC), .REL_CYC(REL_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .nohold_i(nohold_i), .busy_i(busy_i),
    .cnt_i(cnt), .clr_o(clr), .hold_pend_o(hold_pend_o), .bus_oe_o(bus_oe_o),
    .holda_n_o(holda_n_o)
  );

  // R1: reset leaves the bus with the local side
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (holda_n_o && bus_oe_o && !hold_pend_o));
endmodule

// File: tb/bus_hold_ctrl_test.sv
module bus_hold_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_n = 1'b1;
  logic nohold = 1'b0;
  logic busy = 1'b0;
  logic pend, oe, holda_n;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_hold_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n), .nohold_i(nohold),
    .busy_i(busy), .hold_pend_o(pend), .bus_oe_o(oe), .holda_n_o(holda_n)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic ep, input logic eo, input logic eh);
    chk({tag, " pend"}, pend, ep);
    chk({tag, " oe"}, oe, eo);
    chk({tag, " holda_n"}, holda_n, eh);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 1'b0, 1'b1, 1'b1);
    rst_n = 1'b1;
    step();
    step();
    chk_all("R1 after reset", 1'b0, 1'b1, 1'b1);

    // Sweep: local transfer length L against request length H.
    // Edge indices j are relative to k, the first edge that samples the request low.
    for (int L = 0; L <= 5; L++) begin
      for (int dh = 0; dh <= 6; dh++) begin
        int t, h, g, r, e, i;
        t = (L > 3) ? L : 3;          // R3: bus floats after edge k+t
        g = t + 1;                    // R4: acknowledge one edge later
        h = t + 2 + dh;               // release sampled at edge k+h
        r = ((g + 4) > (h + 2)) ? (g + 4) : (h + 2); // R7
        e = r + 3;                    // R8: drivers back on
        i = e + 1;                    // R9: acknowledge released
        for (int j = 0; j <= i + 1; j++) begin
          busy   = (j < L);
          hold_n = (j < h) ? 1'b0 : 1'b1;
          step();
          chk("R2/R10 pend", pend, (j >= 2 && j < i));
          chk("R3/R8 bus_oe", oe, !(j >= t && j < e));
          chk("R4/R7/R9 holda_n", holda_n, !(j >= g && j < i));
        end
        busy = 1'b0;
        hold_n = 1'b1;
        step();
        step();
      end
    end

    // R5: blocking before any request
    nohold = 1'b1;
    hold_n = 1'b0;
    for (int j = 0; j < 12; j++) begin
      step();
      chk_all("R5 blocked", 1'b0, 1'b1, 1'b1);
    end
    hold_n = 1'b1;
    repeat (3) step();
    nohold = 1'b0;
    step();

    // R6: blocking raised while a request waits on a busy local controller
    hold_n = 1'b0;
    busy = 1'b1;
    step(); step(); step();           // after edge k+2
    chk_all("R6 waiting", 1'b1, 1'b1, 1'b1);
    nohold = 1'b1;
    step();                           // after edge k+3
    chk_all("R6 dropped", 1'b0, 1'b1, 1'b1);
    busy = 1'b0;
    for (int j = 0; j < 6; j++) begin
      step();
      chk_all("R6 no grant", 1'b0, 1'b1, 1'b1);
    end
    hold_n = 1'b1;
    repeat (3) step();
    nohold = 1'b0;
    step();

    // R11: request withdrawn while waiting
    hold_n = 1'b0;
    busy = 1'b1;
    step(); step(); step();           // after edge k+2
    chk_all("R11 waiting", 1'b1, 1'b1, 1'b1);
    hold_n = 1'b1;
    step();                           // after edge k+3
    step();                           // after edge k+4, synced request still high
    chk_all("R11 still pending", 1'b1, 1'b1, 1'b1);
    step();                           // after edge k+5
    chk_all("R11 withdrawn", 1'b0, 1'b1, 1'b1);
    busy = 1'b0;
    for (int j = 0; j < 5; j++) begin
      step();
      chk_all("R11 no grant", 1'b0, 1'b1, 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule